// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block manages eight interrupt request lines for a processor. It keeps a pending-request register, an in-service register and a mask register. It drives a single interrupt output whenever an unmasked pending request has higher priority than every level now being serviced. The priority order rotates around a pointer that names the lowest-priority level. At reset the order is fixed: level 0 is highest and level 7 is lowest. The pointer moves through decoded command fields: end-of-interrupt commands, with and without rotation, a set-priority command, and an automatic-rotation flag that applies in auto end-of-interrupt operation.

The acknowledge logic outside the block reads the winning index. It pulses an acknowledge input, which moves the winning request into service. A special-mask enable lets any unmasked request interrupt, whatever is in service. A trigger select chooses between level-sensitive and edge-sensitive capture of the request lines. Bus decoding and cascading stay outside this block.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset, the pending, in-service and mask registers are all zero, and `irq_o` is low. The lowest-priority pointer is 7, so level 0 is highest. Special mask and rotate-in-auto-EOI are both off.
- R2: A mask bit of 1 written through `mask_wr_i`/`mask_i` blocks that request line from `irq_o` and from the winner. Writing 0 enables the line again.
- R3: When `level_mode_i` = 1, each pending bit follows its request line one cycle later, and it clears when the line drops.
- R4: When `level_mode_i` = 0, a pending bit is set only by a 0-to-1 transition of its line. An acknowledge clears it. A line that stays high does not set it again.
- R5: `win_idx_o` gives the unmasked pending level with the highest priority. The priority of level i is (i − pointer − 1) mod 8, where 0 is highest.
- R6: Outside special mask mode, `irq_o` is high only when the winner has strictly higher priority than the highest-priority in-service bit. A winner of equal or lower priority is blocked.
- R7: `ack_i` while `irq_o` is high sets the in-service bit of the winner and clears its pending bit. The in-service bit is not set when `auto_eoi_i` = 1.
- R8: Command {rot,sel,eoi} = 001 is a non-specific EOI. It clears the highest-priority in-service bit. Code 101 does the same and also makes that level the lowest priority.
- R9: Code 011 clears the in-service bit at `cmd_lvl_i`. Code 111 does the same and also makes `cmd_lvl_i` the lowest priority.
- R10: Code 110 makes `cmd_lvl_i` the lowest priority. The other levels follow it in circular order.
- R11: Code 100 turns rotate-in-auto-EOI on and code 000 turns it off. While it is on, an acknowledge with `auto_eoi_i` = 1 makes the acknowledged level the lowest priority.
- R12: `smm_wr_i` with `smm_set_i` = 1 enters special mask mode and with `smm_set_i` = 0 leaves it. In special mask mode, in-service bits do not block `irq_o`.
- R13: Code 010 changes neither the in-service register nor the priority order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Request lines |
| level_mode_i | input | 1 | 1 = level capture, 0 = rising-edge capture |
| mask_wr_i | input | 1 | Write strobe for the mask register |
| mask_i | input | 8 | Mask value, 1 = blocked |
| smm_wr_i | input | 1 | Write strobe for special mask mode |
| smm_set_i | input | 1 | 1 = enter, 0 = leave special mask mode |
| auto_eoi_i | input | 1 | Acknowledge does not set in-service |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_rot_i | input | 1 | Command rotate field |
| cmd_sel_i | input | 1 | Command level-select field |
| cmd_eoi_i | input | 1 | Command end-of-interrupt field |
| cmd_lvl_i | input | 3 | Command level |
| ack_i | input | 1 | Acknowledge pulse from the processor side |
| irq_o | output | 1 | Interrupt to the processor |
| win_idx_o | output | 3 | Index of the winning request |
| isr_o | output | 8 | In-service register |
| irr_o | output | 8 | Pending-request register |

## Verification
The assertions check several properties on every cycle. A raised interrupt never names a masked line. Outside special mask mode, it never names a level already in service. An acknowledge sets the in-service bit, except in auto-EOI operation, where the in-service register stays as it was. Edge capture never records a request without a rising edge. The set-priority and no-operation commands leave the pointer and the in-service register as the requirements say. The resolver itself never reports a winner whose request bit is clear. Only the bench scenarios can show the order that results from a rotation, because that order appears only through later winners. The same holds for nesting, blocking and release across end-of-interrupt commands, for rotation in auto-EOI operation, and for the effect of special mask mode.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // {rot, sel, eoi}
  typedef enum logic [2:0] {
    CMD_AROT_CLR = 3'b000,
    CMD_NS_EOI   = 3'b001,
    CMD_NOP      = 3'b010,
    CMD_SP_EOI   = 3'b011,
    CMD_AROT_SET = 3'b100,
    CMD_ROT_NS   = 3'b101,
    CMD_SET_PRIO = 3'b110,
    CMD_ROT_SP   = 3'b111
  } cmd_e;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  input  logic [W-1:0] low_i,
  output logic         found_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    // scan from lowest to highest priority; last hit wins
    for (int k = N - 1; k >= 0; k--) begin
      if (vec_i[W'(low_i + W'(1) + W'(k))]) begin
        found_o = 1'b1;
        idx_o   = W'(low_i + W'(1) + W'(k));
      end
    end
  end

  always_comb begin
    if (found_o) a_r5_pick_hit: assert (vec_i[idx_o]);
  end
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic         level_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] prev_q, irr_q, rise;

  assign rise  = irq_i & ~prev_q;
  assign irr_o = irr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= irq_i;
      irr_q  <= level_i ? irq_i : ((irr_q & ~clr_i) | rise);
    end
  end

  a_r4_no_edge_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_i && (rise == '0)) |=> ((irr_q & ~$past(irr_q)) == '0));
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int W = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               level_mode_i,
  input  logic               mask_wr_i,
  input  logic [NUM_IRQ-1:0] mask_i,
  input  logic               smm_wr_i,
  input  logic               smm_set_i,
  input  logic               auto_eoi_i,
  input  logic               cmd_valid_i,
  input  logic               cmd_rot_i,
  input  logic               cmd_sel_i,
  input  logic               cmd_eoi_i,
  input  logic [W-1:0]       cmd_lvl_i,
  input  logic               ack_i,
  output logic               irq_o,
  output logic [W-1:0]       win_idx_o,
  output logic [NUM_IRQ-1:0] isr_o,
  output logic [NUM_IRQ-1:0] irr_o
);
  logic [NUM_IRQ-1:0] isr_q, imr_q, irr, pend, irr_clr, isr_set, isr_clr;
  logic [W-1:0]       low_q, low_d, p_idx, s_idx, p_rank, s_rank;
  logic               smm_q, arot_q, arot_d, p_found, s_found, ack_take;
  cmd_e               cmd;

  assign cmd  = cmd_e'({cmd_rot_i, cmd_sel_i, cmd_eoi_i});
  assign pend = irr & ~imr_q;

  irq_req_latch #(.N(NUM_IRQ)) u_latch (
    .clk_i, .rst_ni, .irq_i, .level_i(level_mode_i), .clr_i(irr_clr), .irr_o(irr)
  );

  irq_pick #(.N(NUM_IRQ)) u_pend_pick (
    .vec_i(pend), .low_i(low_q), .found_o(p_found), .idx_o(p_idx)
  );

  irq_pick #(.N(NUM_IRQ)) u_svc_pick (
    .vec_i(isr_q), .low_i(low_q), .found_o(s_found), .idx_o(s_idx)
  );

  // rank 0 = highest priority
  assign p_rank = W'(p_idx - low_q - W'(1));
  assign s_rank = W'(s_idx - low_q - W'(1));

  assign irq_o    = p_found && (smm_q || !s_found || (p_rank < s_rank));
  assign ack_take = ack_i && irq_o;
  assign irr_clr  = ack_take ? (NUM_IRQ'(1) << p_idx) : '0;
  assign isr_set  = (ack_take && !auto_eoi_i) ? (NUM_IRQ'(1) << p_idx) : '0;

  always_comb begin
    isr_clr = '0;
    arot_d  = arot_q;
    low_d   = (ack_take && auto_eoi_i && arot_q) ? p_idx : low_q;
    if (cmd_valid_i) begin
      unique case (cmd)
        CMD_NS_EOI:   if (s_found) isr_clr = NUM_IRQ'(1) << s_idx;
        CMD_ROT_NS:   if (s_found) begin
                        isr_clr = NUM_IRQ'(1) << s_idx;
                        low_d   = s_idx;
                      end
        CMD_SP_EOI:   isr_clr = NUM_IRQ'(1) << cmd_lvl_i;
        CMD_ROT_SP:   begin
                        isr_clr = NUM_IRQ'(1) << cmd_lvl_i;
                        low_d   = cmd_lvl_i;
                      end
        CMD_SET_PRIO: low_d  = cmd_lvl_i;
        CMD_AROT_SET: arot_d = 1'b1;
        CMD_AROT_CLR: arot_d = 1'b0;
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q  <= '0;
      imr_q  <= '0;
      low_q  <= W'(NUM_IRQ - 1);
      smm_q  <= 1'b0;
      arot_q <= 1'b0;
    end else begin
      isr_q  <= (isr_q | isr_set) & ~isr_clr;
      low_q  <= low_d;
      arot_q <= arot_d;
      if (mask_wr_i) imr_q <= mask_i;
      if (smm_wr_i)  smm_q <= smm_set_i;
    end
  end

  assign win_idx_o = p_idx;
  assign isr_o     = isr_q;
  assign irr_o     = irr;

  a_r2_mask_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !imr_q[win_idx_o]);
  a_r6_not_in_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !smm_q) |-> !isr_q[win_idx_o]);
  a_r7_ack_sets_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !auto_eoi_i && !cmd_valid_i) |=> isr_q[$past(win_idx_o)]);
  a_r11_aeoi_keeps_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && auto_eoi_i && !cmd_valid_i) |=> (isr_q == $past(isr_q)));
  a_r10_set_prio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd == CMD_SET_PRIO) |=> (low_q == $past(cmd_lvl_i)));
  a_r13_nop_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd == CMD_NOP && !ack_i) |=> ($stable(isr_q) && $stable(low_q)));
endmodule

// File: tb/irq_prio_resolver_bench.sv
module irq_prio_resolver_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq, mask;
  logic       level, mask_wr, smm_wr, smm_set, aeoi, cvalid, crot, csel, ceoi, ack;
  logic [2:0] clvl;
  logic       irq_out;
  logic [2:0] win;
  logic [7:0] isr, irr;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  irq_prio_resolver u_irq_prio_resolver (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .level_mode_i(level),
    .mask_wr_i(mask_wr), .mask_i(mask), .smm_wr_i(smm_wr), .smm_set_i(smm_set),
    .auto_eoi_i(aeoi), .cmd_valid_i(cvalid), .cmd_rot_i(crot), .cmd_sel_i(csel),
    .cmd_eoi_i(ceoi), .cmd_lvl_i(clvl), .ack_i(ack), .irq_o(irq_out),
    .win_idx_o(win), .isr_o(isr), .irr_o(irr)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset(input logic lvl);
    rst_n = 1'b0; irq = '0; mask = '0; level = lvl; mask_wr = 0; smm_wr = 0;
    smm_set = 0; aeoi = 0; cvalid = 0; crot = 0; csel = 0; ceoi = 0; clvl = '0; ack = 0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic drive_irq(input logic [7:0] v);
    irq = v; step();
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic command(input logic r, input logic s, input logic e, input logic [2:0] l);
    crot = r; csel = s; ceoi = e; clvl = l; cvalid = 1'b1; step(); cvalid = 1'b0;
  endtask

  task automatic write_mask(input logic [7:0] m);
    mask = m; mask_wr = 1'b1; step(); mask_wr = 1'b0;
  endtask

  task automatic write_smm(input logic s);
    smm_set = s; smm_wr = 1'b1; step(); smm_wr = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    chk("R1 irq_o", irq_out, 0);
    chk("R1 isr", isr, 0);
    chk("R1 irr", irr, 0);
  endtask

  task automatic t_fixed_nest();
    do_reset(1'b1);
    drive_irq(8'h24);
    chk("R5 irq_o", irq_out, 1);
    chk("R5 win fixed", win, 2);
    pulse_ack();
    chk("R7 isr set", isr, 8'h04);
    chk("R6 equal blocked", irq_out, 0);
    drive_irq(8'h25);
    chk("R6 higher irq_o", irq_out, 1);
    chk("R6 higher win", win, 0);
    command(0, 0, 1, 0);
    chk("R8 ns eoi", isr, 8'h00);
  endtask

  task automatic t_level();
    do_reset(1'b1);
    drive_irq(8'h10);
    chk("R3 irr follows", irr, 8'h10);
    drive_irq(8'h00);
    chk("R3 irr drops", irr, 8'h00);
    chk("R3 irq_o", irq_out, 0);
  endtask

  task automatic t_rot_ns();
    do_reset(1'b1);
    drive_irq(8'h04);
    pulse_ack();
    drive_irq(8'h00);
    command(1, 0, 1, 0);
    chk("R8 rot ns isr", isr, 0);
    drive_irq(8'h0B);
    chk("R8 rot ns win", win, 3);
  endtask

  task automatic t_specific();
    do_reset(1'b1);
    drive_irq(8'h12);
    pulse_ack();
    chk("R7 isr lvl1", isr, 8'h02);
    drive_irq(8'h10);
    chk("R6 lower blocked", irq_out, 0);
    command(0, 1, 1, 1);
    chk("R9 sp eoi isr", isr, 0);
    chk("R9 sp eoi irq_o", irq_out, 1);
    chk("R9 sp eoi win", win, 4);
    pulse_ack();
    command(1, 1, 1, 4);
    chk("R9 rot sp isr", isr, 0);
    drive_irq(8'h21);
    chk("R9 rot sp win", win, 5);
  endtask

  task automatic t_set_prio();
    do_reset(1'b1);
    command(1, 1, 0, 5);
    drive_irq(8'h41);
    chk("R10 win 6", win, 6);
    drive_irq(8'h81);
    chk("R10 win 7", win, 7);
    drive_irq(8'h03);
    chk("R10 win 0", win, 0);
  endtask

  task automatic t_mask();
    do_reset(1'b1);
    write_mask(8'h01);
    drive_irq(8'h03);
    chk("R2 masked win", win, 1);
    write_mask(8'h03);
    chk("R2 all masked", irq_out, 0);
    write_mask(8'h00);
    chk("R2 unmasked win", win, 0);
    chk("R2 unmasked irq_o", irq_out, 1);
  endtask

  task automatic t_edge();
    do_reset(1'b0);
    drive_irq(8'h08);
    chk("R4 edge recorded", irr, 8'h08);
    chk("R4 win", win, 3);
    pulse_ack();
    chk("R4 ack clears irr", irr, 8'h00);
    step(); step();
    chk("R4 held high no reset", irr, 8'h00);
    command(0, 0, 1, 0);
    chk("R4 no request after eoi", irq_out, 0);
    drive_irq(8'h00);
    drive_irq(8'h08);
    chk("R4 new edge", irr, 8'h08);
  endtask

  task automatic t_aeoi();
    do_reset(1'b1);
    aeoi = 1'b1;
    drive_irq(8'h04);
    pulse_ack();
    chk("R7 aeoi isr clear", isr, 0);
    command(1, 0, 0, 0);
    drive_irq(8'h05);
    chk("R11 before rot", win, 0);
    pulse_ack();
    chk("R11 rotated", win, 2);
    command(0, 0, 0, 0);
    pulse_ack();
    chk("R11 rotation off", win, 2);
    aeoi = 1'b0;
  endtask

  task automatic t_smm();
    do_reset(1'b0);
    drive_irq(8'h10);
    pulse_ack();
    drive_irq(8'h50);
    chk("R12 blocked before smm", irq_out, 0);
    write_smm(1'b1);
    chk("R12 smm irq_o", irq_out, 1);
    chk("R12 smm win", win, 6);
    write_smm(1'b0);
    chk("R12 smm off", irq_out, 0);
    command(0, 1, 0, 4);
    chk("R13 nop isr", isr, 8'h10);
    chk("R13 nop irq_o", irq_out, 0);
    command(0, 1, 1, 4);
    chk("R13 then win", win, 6);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_fixed_nest();
    t_level();
    t_rot_ns();
    t_specific();
    t_set_prio();
    t_mask();
    t_edge();
    t_aeoi();
    t_smm();
    summary();
    $finish;
  end
endmodule